// File: doc/BRIEF.md
# SPI Peripheral Port with Bit-Count Burst Framing

This block is the peripheral (slave) side of an SPI link. It decides where a transfer ends by counting bits, and ignores the chip-select line for that purpose. Software programs a length field holding the bit count minus one, loads outgoing data into a 32-bit transmit FIFO and sets the enable bit. A falling edge on the active-low select line starts a burst. While the burst runs, the block shifts the queued words out on MISO and gathers the bits from MOSI into a 32-bit receive FIFO. The burst closes after exactly the programmed number of bits. Clock edges after that point have no effect.

The block places a burst of any length onto whole FIFO words. When the bit count is not a multiple of 32, the first word carries only the remainder, right-aligned. Every later word carries 32 bits. Within each word the most significant bit travels first. The serial pins are brought into the system clock domain through two-flop synchronisers, so the system clock has to run at least four times faster than SCLK. Clock polarity and phase are programmable, which covers all four SPI modes. One interrupt line combines three enabled sources: transmit FIFO empty, receive data present, and receive FIFO at or above a fill threshold.

Top module: `spi_burst_slave`

## Requirements
- R1: After reset, MISO and IRQ are low, the control and status registers read as 0 and both FIFOs are empty.
- R2: Registers are selected by index: 0 control, 1 interrupt enable, 2 transmit push (write), 3 receive pop (read), 4 status. Control holds enable at bit 0, CPOL at bit 1, CPHA at bit 2 and the length field (bits minus one) at bits 27:16. A control write with bit 28 set asks for more than 4096 bits. Such a write leaves the length field unchanged and still updates bits 2:0.
- R3: A burst starts on a select falling edge only when the block is enabled and idle. It ends after exactly length+1 sampled bits, whatever the select level. Later clock edges push no data and MISO stays low.
- R4: Data is sent and received most significant bit first. When N = length+1 is not a multiple of 32, the first FIFO word carries N mod 32 bits in its low-order bits. Every other word carries 32 bits.
- R5: With CPHA=0, MOSI is sampled on the leading SCLK edge and MISO changes on the trailing edge. With CPHA=1, MISO changes on the leading edge and MOSI is sampled on the trailing edge. The leading edge leaves the CPOL level.
- R6: When the transmit FIFO is empty and a burst needs another word, zeros are shifted out and status bit 0 is set. The bit stays set until a 1 is written to it.
- R7: A completed receive word that finds the receive FIFO full is dropped and sets status bit 1. The bit stays set until a 1 is written to it.
- R8: Receive words left in the FIFO when a new burst starts are discarded.
- R9: IRQ is the OR of three terms: enable bit 0 with transmit FIFO empty, enable bit 3 with receive FIFO not empty, and enable bit 4 with the receive FIFO holding at least RX_THRESH (default 32) words.
- R10: Clearing the enable bit ends any burst at once. MISO goes low and no further receive words are stored.
- R11: Each FIFO holds 64 words. A transmit push to a full FIFO is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive FIFO at index 3) |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected index, combinational |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_ss_n | input | 1 | Active-low select from the master |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| irq | output | 1 | Combined enabled interrupt |

## Verification
Each SCLK edge reaches the shift logic three system clocks after it appears at the pin: two synchroniser stages plus the engine register. MISO therefore settles three cycles after a launch edge. The bench runs SCLK at eight system clocks per half period and reads MISO just before each of its own sampling edges, well after that settling point. Register effects are checked one cycle after the write strobe: IRQ, status bits and control readback are registered, and the read data is combinational on the index. A behavioural model built from queues predicts every MISO bit, every receive word, the FIFO capacity limits and the sticky flags, and each result is compared at the point where it is due.

// File: rtl/spi_burst_pkg.sv
// Shared constants for the bit-count framed SPI peripheral port.
// Assumes a 3-bit register index and fixed bit positions in the control,
// interrupt-enable and status registers.
package spi_burst_pkg;
    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_IEN  = 3'd1;
    localparam logic [2:0] A_TXD  = 3'd2;
    localparam logic [2:0] A_RXD  = 3'd3;
    localparam logic [2:0] A_STAT = 3'd4;

    localparam int CTRL_EN      = 0;
    localparam int CTRL_CPOL    = 1;
    localparam int CTRL_CPHA    = 2;
    localparam int CTRL_LEN_LSB = 16;

    localparam int IEN_TXE = 0;
    localparam int IEN_RXR = 3;
    localparam int IEN_RXT = 4;

    localparam int STAT_UNF = 0;
    localparam int STAT_OVF = 1;
endpackage

// File: rtl/spi_burst_sync.sv
// Two-flop synchroniser bank for asynchronous serial pins.
// Assumes each input bit is independent. RST_VAL gives the reset level
// of each bit, so the select line can come out of reset inactive.
module spi_burst_sync #(
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Purpose: two register stages per pin to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/spi_burst_fifo.sv
// Synchronous FIFO with a flush input. Pushes to a full FIFO and pops
// from an empty one are ignored, and flush takes priority over both.
// The head word is shown on dout with no read latency.
module spi_burst_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign dout    = mem[rp];

    // Purpose: storage array, written on an accepted push.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    // Purpose: read/write pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + AW'(1);
            if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + AW'(1);
            if (do_push && !do_pop)      count <= count + CW'(1);
            else if (do_pop && !do_push) count <= count - CW'(1);
        end
    end
endmodule

// File: rtl/spi_burst_engine.sv
// Burst engine. It detects SCLK edges in the system clock domain, counts
// burst bits, serialises transmit words and packs receive words. Inputs
// must already be synchronised, and the system clock must run at least
// 4x SCLK. The first word of a burst carries N mod DATA_W bits.
module spi_burst_engine #(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [LEN_W-1:0]  blen,
    input  logic              sclk_s,
    input  logic              mosi_s,
    input  logic              ss_n_s,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              tx_empty,
    input  logic              rx_full,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_word,
    output logic              rx_flush,
    output logic              miso,
    output logic              unf_evt,
    output logic              ovf_evt,
    output logic              busy
);
    localparam int CW  = LEN_W + 1;
    localparam int WB  = $clog2(DATA_W);
    localparam int WCW = WB + 1;

    logic              active, sclk_q, ss_q, skip;
    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-2:0] rx_sh;
    logic [WCW-1:0]    tx_wcnt, rx_wcnt, rx_wsize, first_w;
    logic [CW-1:0]     tx_left, rx_left, nbits;
    logic              chg, lead, trail, smp, lau, start, tx_need, rx_wdone;

    // Purpose: edge classification, burst start and per-event strobes.
    always_comb begin
        chg      = sclk_s ^ sclk_q;
        lead     = chg && (sclk_q == cpol);
        trail    = chg && (sclk_q != cpol);
        smp      = active && (cpha ? trail : lead);
        lau      = active && (cpha ? lead : trail);
        start    = !active && en && ss_q && !ss_n_s;
        nbits    = CW'(blen) + CW'(1);
        first_w  = (nbits[WB-1:0] == '0) ? WCW'(DATA_W) : {1'b0, nbits[WB-1:0]};
        tx_need  = lau && !skip && (tx_wcnt == WCW'(1)) && (tx_left != '0);
        rx_wdone = smp && ((rx_wcnt + WCW'(1)) == rx_wsize);
    end

    assign tx_pop   = (start || tx_need) && !tx_empty;
    assign unf_evt  = (start || tx_need) && tx_empty;
    assign rx_word  = {rx_sh, mosi_s};
    assign rx_push  = rx_wdone && !rx_full && en;
    assign ovf_evt  = rx_wdone && rx_full && en;
    assign rx_flush = start;
    assign miso     = active && tx_sh[DATA_W-1];
    assign busy     = active;

    // Purpose: previous pin levels, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            ss_q   <= 1'b1;
        end else begin
            sclk_q <= sclk_s;
            ss_q   <= ss_n_s;
        end
    end

    // Purpose: burst state, transmit shifter and receive packer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            skip     <= 1'b0;
            tx_sh    <= '0;
            tx_wcnt  <= '0;
            tx_left  <= '0;
            rx_sh    <= '0;
            rx_wcnt  <= '0;
            rx_wsize <= '0;
            rx_left  <= '0;
        end else if (!en) begin
            active <= 1'b0;                         // R10: drop to idle
        end else if (start) begin
            active   <= 1'b1;
            skip     <= cpha;                       // R5: first leading edge only presents
            tx_sh    <= tx_empty ? '0 : (tx_word << (DATA_W - int'(first_w)));
            tx_wcnt  <= first_w;                    // R4: short first word
            tx_left  <= nbits - CW'(first_w);
            rx_sh    <= '0;
            rx_wcnt  <= '0;
            rx_wsize <= first_w;
            rx_left  <= nbits;
        end else begin
            if (smp) begin
                if (rx_wdone) begin
                    rx_sh    <= '0;
                    rx_wcnt  <= '0;
                    rx_wsize <= WCW'(DATA_W);
                end else begin
                    rx_sh   <= rx_word[DATA_W-2:0];
                    rx_wcnt <= rx_wcnt + WCW'(1);
                end
                rx_left <= rx_left - CW'(1);
                if (rx_left == CW'(1)) active <= 1'b0;   // R3: exact bit count
            end
            if (lau) begin
                if (skip) begin
                    skip <= 1'b0;
                end else if (tx_need) begin
                    tx_sh   <= tx_empty ? '0 : tx_word;  // R6: zero fill
                    tx_wcnt <= WCW'(DATA_W);
                    tx_left <= tx_left - CW'(DATA_W);
                end else begin
                    tx_sh   <= tx_sh << 1;
                    tx_wcnt <= (tx_wcnt == '0) ? '0 : tx_wcnt - WCW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/spi_burst_slave.sv
// Top level of the SPI peripheral port with bit-count framing. It holds
// the register interface, the two FIFOs, the pin synchronisers, the burst
// engine and the interrupt combiner. Assumes DATA_W = 32 register words
// and a system clock at least 4x SCLK.
module spi_burst_slave
    import spi_burst_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int FIFO_DEPTH = 64,
    parameter int LEN_W      = 12,
    parameter int RX_THRESH  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              spi_sclk,
    input  logic              spi_ss_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              irq
);
    localparam int CNTW    = $clog2(FIFO_DEPTH + 1);
    localparam int REJ_BIT = CTRL_LEN_LSB + LEN_W;

    logic             ctrl_en, ctrl_cpol, ctrl_cpha;
    logic [LEN_W-1:0] ctrl_len;
    logic             ien_txe, ien_rxr, ien_rxt;
    logic             st_unf, st_ovf;
    logic             ctrl_len_rej, wr_ctrl, wr_ien, wr_stat;

    logic [2:0]        pins_s;
    logic              tx_pop, tx_empty, tx_full, rx_push, rx_flush;
    logic              rx_full, rx_empty, unf_evt, ovf_evt, busy;
    logic [DATA_W-1:0] tx_head, rx_head, rx_word;
    logic [CNTW-1:0]   tx_count, rx_count;
    logic              unused_bits;

    assign wr_ctrl      = reg_wr && (reg_addr == A_CTRL);
    assign wr_ien       = reg_wr && (reg_addr == A_IEN);
    assign wr_stat      = reg_wr && (reg_addr == A_STAT);
    assign ctrl_len_rej = wr_ctrl && reg_wdata[REJ_BIT];
    assign unused_bits  = ^{reg_wdata[DATA_W-1:REJ_BIT+1], reg_wdata[CTRL_LEN_LSB-1:5],
                            tx_count, tx_full, busy};

    // Purpose: control and interrupt-enable registers (R2).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en   <= 1'b0;
            ctrl_cpol <= 1'b0;
            ctrl_cpha <= 1'b0;
            ctrl_len  <= '0;
            ien_txe   <= 1'b0;
            ien_rxr   <= 1'b0;
            ien_rxt   <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_en   <= reg_wdata[CTRL_EN];
                ctrl_cpol <= reg_wdata[CTRL_CPOL];
                ctrl_cpha <= reg_wdata[CTRL_CPHA];
                if (!ctrl_len_rej) ctrl_len <= reg_wdata[CTRL_LEN_LSB +: LEN_W];
            end
            if (wr_ien) begin
                ien_txe <= reg_wdata[IEN_TXE];
                ien_rxr <= reg_wdata[IEN_RXR];
                ien_rxt <= reg_wdata[IEN_RXT];
            end
        end
    end

    // Purpose: sticky error flags, set by events and cleared by writing 1 (R6, R7).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_unf <= 1'b0;
            st_ovf <= 1'b0;
        end else begin
            st_unf <= unf_evt || (st_unf && !(wr_stat && reg_wdata[STAT_UNF]));
            st_ovf <= ovf_evt || (st_ovf && !(wr_stat && reg_wdata[STAT_OVF]));
        end
    end

    // Purpose: read data mux selected by register index.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: begin
                reg_rdata[CTRL_EN]   = ctrl_en;
                reg_rdata[CTRL_CPOL] = ctrl_cpol;
                reg_rdata[CTRL_CPHA] = ctrl_cpha;
                reg_rdata[CTRL_LEN_LSB +: LEN_W] = ctrl_len;
            end
            A_IEN: begin
                reg_rdata[IEN_TXE] = ien_txe;
                reg_rdata[IEN_RXR] = ien_rxr;
                reg_rdata[IEN_RXT] = ien_rxt;
            end
            A_RXD:  reg_rdata = rx_head;
            A_STAT: begin
                reg_rdata[STAT_UNF] = st_unf;
                reg_rdata[STAT_OVF] = st_ovf;
            end
            default: reg_rdata = '0;
        endcase
    end

    // Purpose: combined interrupt output (R9).
    always_comb begin
        irq = (ien_txe && tx_empty) || (ien_rxr && !rx_empty) ||
              (ien_rxt && (rx_count >= CNTW'(RX_THRESH)));
    end

    spi_burst_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({spi_mosi, spi_ss_n, spi_sclk}),
        .q(pins_s)
    );

    spi_burst_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(1'b0),
        .push(reg_wr && (reg_addr == A_TXD)), .din(reg_wdata),
        .pop(tx_pop), .dout(tx_head), .count(tx_count),
        .full(tx_full), .empty(tx_empty)
    );

    spi_burst_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush),
        .push(rx_push), .din(rx_word),
        .pop(reg_rd && (reg_addr == A_RXD)), .dout(rx_head), .count(rx_count),
        .full(rx_full), .empty(rx_empty)
    );

    spi_burst_engine #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .en(ctrl_en), .cpol(ctrl_cpol), .cpha(ctrl_cpha),
        .blen(ctrl_len), .sclk_s(pins_s[0]), .mosi_s(pins_s[2]), .ss_n_s(pins_s[1]),
        .tx_word(tx_head), .tx_empty(tx_empty), .rx_full(rx_full),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word), .rx_flush(rx_flush),
        .miso(spi_miso), .unf_evt(unf_evt), .ovf_evt(ovf_evt), .busy(busy)
    );
endmodule

// File: rtl/spi_burst_checker.sv
// Assertion checker bound into spi_burst_slave. It watches the register
// side, the engine events and the FIFO state over time.
module spi_burst_checker #(
    parameter int LEN_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctrl_en,
    input logic             spi_miso,
    input logic             ctrl_len_rej,
    input logic [LEN_W-1:0] ctrl_len,
    input logic             unf_evt,
    input logic             ovf_evt,
    input logic             st_unf,
    input logic             st_ovf,
    input logic             rx_flush,
    input logic             rx_empty
);
    // R10: a disabled port drives MISO low from the next cycle
    p_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |=> !spi_miso);

    // R2: an oversize length request leaves the field unchanged
    p_len_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_len_rej |=> $stable(ctrl_len));

    // R6: a transmit underflow is recorded
    p_unf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        unf_evt |=> st_unf);

    // R7: a dropped receive word is recorded
    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> st_ovf);

    // R8: starting a burst empties the receive FIFO
    p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |=> rx_empty);
endmodule

bind spi_burst_slave spi_burst_checker #(.LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .spi_miso(spi_miso),
    .ctrl_len_rej(ctrl_len_rej), .ctrl_len(ctrl_len), .unf_evt(unf_evt),
    .ovf_evt(ovf_evt), .st_unf(st_unf), .st_ovf(st_ovf),
    .rx_flush(rx_flush), .rx_empty(rx_empty)
);

// File: tb/tb_spi_burst_slave.sv
// Self-checking bench. A behavioural queue model predicts MISO bits,
// receive words and status, and the bench acts as the SPI master.
module tb_spi_burst_slave;
    import spi_burst_pkg::*;

    localparam int H = 8;   // SCLK half period in system clocks

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        spi_sclk = 1'b0, spi_ss_n = 1'b1, spi_mosi = 1'b0;
    logic        spi_miso, irq;

    always #10 clk = ~clk;   // 50 MHz

    spi_burst_slave dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .spi_sclk(spi_sclk), .spi_ss_n(spi_ss_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .irq(irq)
    );

    int total = 0, bad = 0;
    bit done = 0;
    logic [31:0] txq[$];
    logic [31:0] rxq[$];
    bit m_cpol = 0, m_cpha = 0;
    int m_len = 0;

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic hold(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic set_ctrl(bit en, bit cpol, bit cpha, int len);
        logic [31:0] d = '0;
        d[0] = en; d[1] = cpol; d[2] = cpha; d[27:16] = len[11:0];
        m_cpol = cpol; m_cpha = cpha; m_len = len;
        reg_write(A_CTRL, d);
    endtask

    task automatic push_tx(logic [31:0] w);
        reg_write(A_TXD, w);
        if (txq.size() < 64) txq.push_back(w);   // R11 model capacity
    endtask

    // Drive one burst as master and compare MISO against the model.
    task automatic run_burst(int nbits, int extra, int kill_at, string req);
        bit mo[$], ex[$], got[$];
        logic [31:0] w;
        int k, idx, mism, fb;
        for (int i = 0; i < nbits + extra; i++) mo.push_back(1'($urandom_range(0, 1)));
        k = (nbits % 32 == 0) ? 32 : nbits % 32;
        idx = 0;
        while (idx < nbits) begin
            int ws = (idx == 0) ? k : 32;
            w = (txq.size() > 0) ? txq.pop_front() : 32'h0;
            for (int b = ws - 1; b >= 0; b--) ex.push_back(w[b]);
            idx += ws;
        end
        for (int i = 0; i < extra; i++) ex.push_back(1'b0);
        if (kill_at >= 0)
            for (int i = kill_at; i < ex.size(); i++) ex[i] = 1'b0;
        rxq.delete();
        idx = 0;
        while (idx < nbits) begin
            int ws = (idx == 0) ? k : 32;
            w = '0;
            for (int b = 0; b < ws; b++) begin w = {w[30:0], mo[idx]}; idx++; end
            if ((kill_at < 0 || idx - 1 < kill_at) && rxq.size() < 64) rxq.push_back(w);
        end
        spi_sclk = m_cpol;
        hold(H);
        spi_ss_n = 1'b0;
        hold(H);
        for (int i = 0; i < nbits + extra; i++) begin
            if (i == kill_at) set_ctrl(0, m_cpol, m_cpha, m_len);
            if (!m_cpha) begin
                spi_mosi = mo[i];
                hold(H);
                got.push_back(spi_miso);
                spi_sclk = ~spi_sclk;
                hold(H);
                spi_sclk = ~spi_sclk;
            end else begin
                spi_sclk = ~spi_sclk;
                spi_mosi = mo[i];
                hold(H);
                got.push_back(spi_miso);
                spi_sclk = ~spi_sclk;
                hold(H);
            end
        end
        hold(H);
        spi_ss_n = 1'b1;
        hold(H);
        mism = 0; fb = -1;
        for (int i = 0; i < ex.size(); i++)
            if (got[i] !== ex[i]) begin mism++; if (fb < 0) fb = i; end
        chk(mism == 0, req, $sformatf("miso bits (first bad %0d)", fb),
            (fb < 0) ? 64'd0 : 64'(got[fb]), (fb < 0) ? 64'd0 : 64'(ex[fb]));
    endtask

    // Pop every predicted receive word, then confirm the FIFO is empty.
    task automatic drain(string req);
        logic [31:0] d;
        int n = rxq.size();
        for (int i = 0; i < n; i++) begin
            reg_read(A_RXD, d);
            chk(d === rxq[i], req, $sformatf("rx word %0d", i), 64'(d), 64'(rxq[i]));
        end
        reg_write(A_IEN, 32'h8);
        hold(1);
        chk(irq === 1'b0, "R9", "rx ready irq after drain", 64'(irq), 64'd0);
        reg_write(A_IEN, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        hold(5);
        rst_n = 1'b1;
        hold(2);
        // R1 reset state
        chk(spi_miso === 1'b0, "R1", "miso after reset", 64'(spi_miso), 64'd0);
        chk(irq === 1'b0, "R1", "irq after reset", 64'(irq), 64'd0);
        reg_read(A_CTRL, d);
        chk(d === 32'h0, "R1", "ctrl after reset", 64'(d), 64'd0);
        reg_read(A_STAT, d);
        chk(d === 32'h0, "R1", "status after reset", 64'(d), 64'd0);
        // R9 transmit-empty source
        reg_write(A_IEN, 32'h1);
        hold(1);
        chk(irq === 1'b1, "R9", "tx empty irq", 64'(irq), 64'd1);
        reg_write(A_IEN, 32'h0);
        // R2 layout and rejected length
        set_ctrl(1, 0, 0, 63);
        reg_read(A_CTRL, d);
        chk(d === 32'h003F_0001, "R2", "ctrl readback", 64'(d), 64'h003F_0001);
        reg_write(A_CTRL, 32'h1005_0003);
        reg_read(A_CTRL, d);
        chk(d === 32'h003F_0003, "R2", "oversize length rejected", 64'(d), 64'h003F_0003);
        // R3 R4 R5 mode 0, 64 bits
        set_ctrl(1, 0, 0, 63);
        push_tx(32'hA5C3_0F96);
        push_tx(32'h1234_5678);
        run_burst(64, 0, -1, "R3");
        drain("R4");
        // R4 short first word: 40 bits = 8 + 32
        set_ctrl(1, 0, 0, 39);
        push_tx(32'h0000_00C7);
        push_tx(32'hDEAD_BEEF);
        run_burst(40, 0, -1, "R4");
        drain("R4");
        // R5 remaining modes
        for (int m = 1; m < 4; m++) begin
            set_ctrl(1, m[1], m[0], 15);
            push_tx(32'h0000_B14E + 32'(m));
            run_burst(16, 0, -1, "R5");
            drain("R5");
        end
        // R3 extra clocks after the burst are ignored
        set_ctrl(1, 0, 0, 7);
        push_tx(32'h0000_005A);
        run_burst(8, 16, -1, "R3");
        drain("R3");
        // R8 stale receive word flushed by the next burst
        push_tx(32'h0000_0033);
        run_burst(8, 0, -1, "R8");
        push_tx(32'h0000_00E1);
        run_burst(8, 0, -1, "R8");
        drain("R8");
        // R6 underflow: one word for a 64-bit burst
        set_ctrl(1, 0, 0, 63);
        push_tx(32'h8001_7FFE);
        run_burst(64, 0, -1, "R6");
        drain("R6");
        reg_read(A_STAT, d);
        chk(d === 32'h1, "R6", "underflow flag", 64'(d), 64'h1);
        reg_write(A_STAT, 32'h1);
        reg_read(A_STAT, d);
        chk(d === 32'h0, "R6", "underflow cleared", 64'(d), 64'h0);
        // R7 R11 overflow: 65 words each way
        set_ctrl(1, 0, 0, 2079);
        for (int i = 0; i < 65; i++) push_tx(32'h5EED_0000 + 32'(i * 7919));
        run_burst(2080, 0, -1, "R11");
        reg_read(A_STAT, d);
        chk(d === 32'h3, "R7", "overflow and underflow flags", 64'(d), 64'h3);
        reg_write(A_IEN, 32'h10);
        hold(1);
        chk(irq === 1'b1, "R9", "rx threshold irq", 64'(irq), 64'd1);
        reg_write(A_IEN, 32'h0);
        drain("R7");
        reg_write(A_STAT, 32'h2);
        reg_read(A_STAT, d);
        chk(d === 32'h1, "R7", "overflow cleared alone", 64'(d), 64'h1);
        reg_write(A_STAT, 32'h1);
        // R10 disable in the middle of a burst
        set_ctrl(1, 0, 0, 63);
        push_tx(32'hFFFF_FFFF);
        push_tx(32'hFFFF_FFFF);
        run_burst(64, 0, 40, "R10");
        drain("R10");
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule